// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received Ethernet frames in host memory. The host keeps a ring of receive descriptors in shared memory. Each descriptor names a buffer, gives that buffer's size, and carries an ownership bit. When a frame starts arriving on the byte stream, the block reads the descriptor at its current ring index. If the device owns that descriptor, the block fills the buffer one byte at a time. When the buffer runs out and more bytes are still coming, the block continues the frame in the next descriptor.

When the frame is complete, the block writes back the message length and the status flags, and clears the ownership bit in the same write. It then pulses a receive interrupt request. If the descriptor needed to start a frame still belongs to the host, the block discards the whole frame and pulses a missed-frame line instead. If a frame must continue into a descriptor that the host still owns, the block ends the frame in the buffer it already holds, marks a buffer error there, and discards the remaining bytes.

Shared memory is modelled as a single synchronous RAM port. The port is 16 bits wide, takes word addresses, has byte enables, and returns read data one cycle after the request. The port is always granted.

The controller runs through the following states:
- `S_IDLE` waits for a frame.
- `S_RD_FLAG`, `S_RD_BASE` and `S_RD_LEN` read the descriptor's words.
- `S_CHECK` decides what to do with the descriptor.
- `S_FILL` writes frame bytes into the buffer.
- `S_WB_LEN` writes the message length.
- `S_WB_FLAG` writes the flag word.
- `S_DROP` discards the rest of a frame.

The transitions are:
- `S_IDLE` goes to `S_RD_FLAG` on a valid byte.
- The three read states always step in order to `S_CHECK`.
- `S_CHECK` goes to one of three states:
  - `S_FILL` for an owned start descriptor.
  - `S_DROP` for a host-owned start descriptor. This is a miss.
  - `S_WB_FLAG` for an owned chain target, or `S_WB_LEN` for a host-owned chain target. Either one hands back the previous descriptor.
- `S_FILL` goes to `S_WB_LEN` on the last byte, or to `S_RD_FLAG` when the buffer is full and another byte is waiting.
- `S_WB_LEN` always goes to `S_WB_FLAG`.
- `S_WB_FLAG` goes to a state chosen earlier: `S_IDLE` after a normal end, `S_FILL` after a chain step, or `S_DROP` after a buffer error.
- `S_DROP` goes to `S_IDLE` once the last byte is taken.

Top module: `rxdesc_ring_writer`

## Requirements
- R1: Descriptor layout and addressing:
  - Descriptor i occupies four 16-bit words starting at byte address `cfg_ring_base + 8*i`.
  - Word 0 is the low 16 bits of the buffer address.
  - Word 1 holds the flag byte in bits [15:8] and the buffer address bits [23:16] in bits [7:0].
  - Word 2 is the buffer length and word 3 is the message length.
  - `mem_addr` is the byte address divided by 2.
  - A byte at an even byte address travels in `mem_wdata[7:0]` with `mem_be` = 01. A byte at an odd address travels in bits [15:8] with `mem_be` = 10.
- R2: The block writes buffer data only through descriptors whose flag bit 7 (ownership) reads 1. Every flag word it writes back has bit 7 = 0.
- R3: The usable size of a buffer is 4096 minus the low 12 bits of word 2, so a value of 0 gives 4096. Byte k of a buffer goes to the buffer address plus k, and no byte is written past the usable size.
- R4: A frame that fits in one buffer gets flag byte 0x03 (start bit 1, end bit 0) plus any error bits. Its message length is the number of stream bytes in the frame, CRC bytes included.
- R5: A frame larger than its buffer continues in the next descriptor:
  - The first descriptor of the frame is handed back with flags 0x02.
  - A middle descriptor is handed back with flags 0x00.
  - The last descriptor gets end bit 0 and the total message length.
  - Only the last descriptor carries error bits and a message length.
- R6: Error bits in the last descriptor come from the inputs that accompany the last byte: framing error in bit 5, overflow in bit 4, CRC error in bit 3. Bit 6 is set when any error bit is set.
- R7: If a frame must continue into a host-owned descriptor:
  - The descriptor already filled is handed back with end bit 0, buffer-error bit 2 and bit 6 set, plus the start bit if it was the first descriptor.
  - Its message length is the number of bytes stored.
  - The remaining bytes of the frame are accepted and discarded, with no memory write.
  - The next frame starts at that host-owned descriptor.
- R8: The ring index starts at 0. It advances once per descriptor handed back with data and wraps modulo 2^`cfg_ring_log2`.
- R9: For a descriptor that ends a frame, the message length word is written before the flag word. The flag word is always the last write to a descriptor.
- R10: If the descriptor at the ring index is host-owned when a frame starts:
  - The frame is accepted and discarded, with no memory write.
  - `rx_miss` pulses for one cycle.
  - The ring index is unchanged.
- R11: `rx_int` pulses for one cycle for each frame whose end descriptor is written back. The pulse comes in the cycle of that flag-word write and never coincides with `rx_miss`.
- R12: After reset, `rx_ready`, `mem_req`, `rx_int` and `rx_miss` are low, and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | 24 | Byte address of descriptor 0 (8-byte aligned) |
| cfg_ring_log2 | input | LOG_W (3) | log2 of the ring size |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err_frame | input | 1 | Framing error, sampled with the last byte |
| rx_err_ovf | input | 1 | Overflow error, sampled with the last byte |
| rx_err_crc | input | 1 | CRC error, sampled with the last byte |
| rx_ready | output | 1 | Byte accepted when high together with `rx_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 23 | Memory word address |
| mem_be | output | 2 | Byte enables for a write |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| rx_int | output | 1 | Receive-complete pulse |
| rx_miss | output | 1 | Missed-frame pulse |

## Verification
If the ring index drifts, the next descriptor write lands on the wrong word address. A scoreboard of expected descriptor writes catches this at the first write-back after the drift. A wrong buffer or capacity count shows up in two ways: a chain step happens at the wrong byte, which moves or adds a flag write at once, or a message length is wrong when the frame ends. A lost or duplicated ownership decision appears as an unexpected descriptor write, or as a missing `rx_int` or `rx_miss` pulse, within the frame being received.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    // Buffer addresses are 24 bits: 16 low bits in word 0, 8 high bits in word 1.
    localparam int ADDR_W = 24;
    // Buffer and message lengths are 12-bit quantities.
    localparam int LEN_W  = 12;

    // Flag byte bit positions (the host decodes them).
    localparam int F_OWN  = 7;
    localparam int F_ERR  = 6;
    localparam int F_FRAM = 5;
    localparam int F_OFLO = 4;
    localparam int F_CRC  = 3;
    localparam int F_BUFF = 2;
    localparam int F_STP  = 1;
    localparam int F_ENP  = 0;

    // Word offsets inside a descriptor.
    localparam logic [1:0] W_BASE = 2'd0;
    localparam logic [1:0] W_FLAG = 2'd1;
    localparam logic [1:0] W_BLEN = 2'd2;
    localparam logic [1:0] W_MLEN = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_FLAG,
        S_RD_BASE,
        S_RD_LEN,
        S_CHECK,
        S_FILL,
        S_WB_LEN,
        S_WB_FLAG,
        S_DROP
    } rxdw_state_e;

endpackage

// File: rtl/rxdw_ring_index.sv
module rxdw_ring_index #(
    parameter int IDX_W = 7,
    parameter int LOG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOG_W-1:0] ring_log2,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] mask;

    // The ring size is a power of two, so the wrap is a mask of size minus one.
    assign mask = ~({IDX_W{1'b1}} << ring_log2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx + 1'b1) & mask;
        end
    end

    // R8: the index never leaves the configured ring
    a_r8_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (idx & ~mask) == '0);

endmodule

// File: rtl/rxdw_addr_gen.sv
module rxdw_addr_gen
    import rxdw_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic [1:0]        desc_word,
    input  logic              data_sel,
    input  logic [ADDR_W-1:0] data_addr,
    output logic [ADDR_W-2:0] word_addr,
    output logic [1:0]        byte_en
);

    localparam int PAD = ADDR_W - 1 - IDX_W - 2;

    logic [ADDR_W-2:0] desc_off;

    // A descriptor is four words long, so its word offset is idx*4 + word.
    assign desc_off = {{PAD{1'b0}}, desc_idx, desc_word};

    always_comb begin
        if (data_sel) begin
            word_addr = data_addr[ADDR_W-1:1];
            byte_en   = data_addr[0] ? 2'b10 : 2'b01;
        end else begin
            word_addr = ring_base[ADDR_W-1:1] + desc_off;
            byte_en   = 2'b11;
        end
    end

endmodule

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
    import rxdw_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err_frame,
    input  logic              rx_err_ovf,
    input  logic              rx_err_crc,
    output logic              rx_ready,
    input  logic [IDX_W-1:0]  idx,
    output logic              idx_adv,
    output logic [IDX_W-1:0]  desc_idx,
    output logic [1:0]        desc_word,
    output logic              data_sel,
    output logic [ADDR_W-1:0] data_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              rx_int,
    output logic              rx_miss
);

    localparam logic [LEN_W:0] FULL_CAP = 1 << LEN_W;

    rxdw_state_e      state, state_nx, after_q;
    logic             chain_q;
    logic             own_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W:0]   cap_q;
    logic [LEN_W:0]   used_q;
    logic [LEN_W-1:0] total_q;
    logic             first_q;
    logic [IDX_W-1:0] wb_idx_q;
    logic [7:0]       wb_hi_q;
    logic [7:0]       wb_flags_q;
    logic             wb_end_q;

    logic room, accept, need_chain, any_err;

    assign room       = (used_q < cap_q);
    assign accept     = (state == S_FILL) && rx_valid && room;
    assign need_chain = (state == S_FILL) && rx_valid && !room;
    assign any_err    = rx_err_frame | rx_err_ovf | rx_err_crc;
    assign data_addr  = base_q + {{(ADDR_W-LEN_W-1){1'b0}}, used_q};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (rx_valid) state_nx = S_RD_FLAG;
            S_RD_FLAG: state_nx = S_RD_BASE;
            S_RD_BASE: state_nx = S_RD_LEN;
            S_RD_LEN:  state_nx = S_CHECK;
            S_CHECK: begin
                if (!chain_q) state_nx = own_q ? S_FILL : S_DROP;
                else          state_nx = own_q ? S_WB_FLAG : S_WB_LEN;
            end
            S_FILL: begin
                if (accept && rx_last) state_nx = S_WB_LEN;
                else if (need_chain)   state_nx = S_RD_FLAG;
            end
            S_WB_LEN:  state_nx = S_WB_FLAG;
            S_WB_FLAG: state_nx = after_q;
            S_DROP:    if (rx_valid && rx_last) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_q    <= S_IDLE;
            chain_q    <= 1'b0;
            own_q      <= 1'b0;
            base_q     <= '0;
            cap_q      <= '0;
            used_q     <= '0;
            total_q    <= '0;
            first_q    <= 1'b0;
            wb_idx_q   <= '0;
            wb_hi_q    <= '0;
            wb_flags_q <= '0;
            wb_end_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (rx_valid) chain_q <= 1'b0;
                S_RD_BASE: begin
                    own_q         <= mem_rdata[8+F_OWN];
                    base_q[23:16] <= mem_rdata[7:0];
                end
                S_RD_LEN: base_q[15:0] <= mem_rdata;
                S_CHECK: begin
                    cap_q  <= FULL_CAP - {1'b0, mem_rdata[LEN_W-1:0]};
                    used_q <= '0;
                    if (!chain_q) begin
                        first_q <= 1'b1;
                        total_q <= '0;
                    end else if (own_q) begin
                        wb_flags_q        <= '0;
                        wb_flags_q[F_STP] <= first_q;
                        wb_end_q          <= 1'b0;
                        after_q           <= S_FILL;
                        first_q           <= 1'b0;
                    end else begin
                        wb_flags_q        <= '0;
                        wb_flags_q[F_STP] <= first_q;
                        wb_flags_q[F_ENP] <= 1'b1;
                        wb_flags_q[F_BUFF] <= 1'b1;
                        wb_flags_q[F_ERR] <= 1'b1;
                        wb_end_q          <= 1'b1;
                        after_q           <= S_DROP;
                    end
                end
                S_FILL: begin
                    if (accept) begin
                        used_q  <= used_q + 1'b1;
                        total_q <= total_q + 1'b1;
                        if (rx_last) begin
                            wb_idx_q           <= idx;
                            wb_hi_q            <= base_q[23:16];
                            wb_flags_q         <= '0;
                            wb_flags_q[F_STP]  <= first_q;
                            wb_flags_q[F_ENP]  <= 1'b1;
                            wb_flags_q[F_FRAM] <= rx_err_frame;
                            wb_flags_q[F_OFLO] <= rx_err_ovf;
                            wb_flags_q[F_CRC]  <= rx_err_crc;
                            wb_flags_q[F_ERR]  <= any_err;
                            wb_end_q           <= 1'b1;
                            after_q            <= S_IDLE;
                        end
                    end else if (need_chain) begin
                        wb_idx_q <= idx;
                        wb_hi_q  <= base_q[23:16];
                        chain_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rx_ready  = 1'b0;
        idx_adv   = 1'b0;
        desc_idx  = idx;
        desc_word = W_FLAG;
        data_sel  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        rx_int    = 1'b0;
        rx_miss   = 1'b0;
        unique case (state)
            S_RD_FLAG: begin mem_req = 1'b1; desc_word = W_FLAG; end
            S_RD_BASE: begin mem_req = 1'b1; desc_word = W_BASE; end
            S_RD_LEN:  begin mem_req = 1'b1; desc_word = W_BLEN; end
            S_CHECK:   rx_miss = !chain_q && !own_q;
            S_FILL: begin
                rx_ready = room;
                if (accept) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    data_sel  = 1'b1;
                    mem_wdata = {rx_data, rx_data};
                end
                idx_adv = (accept && rx_last) || need_chain;
            end
            S_WB_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                desc_idx  = wb_idx_q;
                desc_word = W_MLEN;
                mem_wdata = {{(16-LEN_W){1'b0}}, total_q};
            end
            S_WB_FLAG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                desc_idx  = wb_idx_q;
                desc_word = W_FLAG;
                mem_wdata = {wb_flags_q, wb_hi_q};
                rx_int    = wb_end_q;
            end
            S_DROP:  rx_ready = 1'b1;
            default: ;
        endcase
    end

    // R9: an end descriptor's length is written in the cycle before its flags
    a_r9_len_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB_FLAG && wb_end_q) |-> $past(state) == S_WB_LEN);

    // R2: a flag word written back never keeps device ownership
    a_r2_flag_handback: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !data_sel && desc_word == W_FLAG) |-> !mem_wdata[15]);

    // R3: buffer writes stay below the usable size
    a_r3_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && data_sel) |-> used_q < cap_q);

    // R10: a miss is followed by no memory write
    a_r10_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_miss |=> !mem_we);

    // R11: the completion pulse lasts a single cycle
    a_r11_int_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |=> !rx_int);

    // R11: completion and miss never coincide
    a_r11_int_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_int, rx_miss}));

endmodule

// File: rtl/rxdesc_ring_writer.sv
module rxdesc_ring_writer
    import rxdw_pkg::*;
#(
    parameter int MAX_LOG2 = 7,
    localparam int IDX_W   = MAX_LOG2,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [LOG_W-1:0]  cfg_ring_log2,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err_frame,
    input  logic              rx_err_ovf,
    input  logic              rx_err_crc,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              rx_int,
    output logic              rx_miss
);

    logic [IDX_W-1:0]  idx, desc_idx;
    logic              idx_adv, data_sel;
    logic [1:0]        desc_word;
    logic [ADDR_W-1:0] data_addr;

    rxdw_ring_index #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_log2 (cfg_ring_log2),
        .advance   (idx_adv),
        .idx       (idx)
    );

    rxdw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .rx_err_frame (rx_err_frame),
        .rx_err_ovf   (rx_err_ovf),
        .rx_err_crc   (rx_err_crc),
        .rx_ready     (rx_ready),
        .idx          (idx),
        .idx_adv      (idx_adv),
        .desc_idx     (desc_idx),
        .desc_word    (desc_word),
        .data_sel     (data_sel),
        .data_addr    (data_addr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .rx_int       (rx_int),
        .rx_miss      (rx_miss)
    );

    rxdw_addr_gen #(.IDX_W(IDX_W)) u_addr (
        .ring_base (cfg_ring_base),
        .desc_idx  (desc_idx),
        .desc_word (desc_word),
        .data_sel  (data_sel),
        .data_addr (data_addr),
        .word_addr (mem_addr),
        .byte_en   (mem_be)
    );

endmodule

// File: tb/rxdesc_ring_writer_tb_top.sv
module rxdesc_ring_writer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_ring_base = 24'h0;
    logic [2:0]  cfg_ring_log2 = 3'd2;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err_frame = 1'b0, rx_err_ovf = 1'b0, rx_err_crc = 1'b0;
    logic        rx_ready, mem_req, mem_we, rx_int, rx_miss;
    logic [22:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    rxdesc_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
        .cfg_ring_log2(cfg_ring_log2), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_err_frame(rx_err_frame), .rx_err_ovf(rx_err_ovf),
        .rx_err_crc(rx_err_crc), .rx_ready(rx_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_int(rx_int),
        .rx_miss(rx_miss)
    );

    // Shared memory model: 4096 words, read data one cycle after the request.
    logic [15:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_be[0]) mem[mem_addr[11:0]][7:0]  <= mem_wdata[7:0];
                if (mem_be[1]) mem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
            end else begin
                mem_rdata <= mem[mem_addr[11:0]];
            end
        end
    end

    int checks = 0, errors = 0;
    int got_int = 0, got_miss = 0, exp_int = 0, exp_miss = 0;
    bit done = 1'b0;

    typedef struct packed { logic [11:0] waddr; logic [15:0] data; } wr_t;
    wr_t   exp_q[$];
    string tag_q[$];

    // Host-side model of the ring.
    int cap [4] = '{64, 16, 16, 64};
    bit m_own [4];
    int m_idx = 0;

    function automatic int buf_base(int i);
        return 32'h400 + i * 32'h100;
    endfunction

    task automatic set_desc(int i, bit own);
        mem[4*i]   = buf_base(i);
        mem[4*i+1] = {own ? 8'h80 : 8'h00, 8'h00};
        mem[4*i+2] = 16'hF000 | 16'((4096 - cap[i]) & 12'hFFF);
        mem[4*i+3] = 16'h0;
        m_own[i]   = own;
    endtask

    task automatic push_wb(int i, logic [7:0] flags, int len, bit is_end, string tg);
        if (is_end) begin
            exp_q.push_back({12'(4*i+3), 16'(len)});
            tag_q.push_back({tg, " R1 R9 length word"});
        end
        exp_q.push_back({12'(4*i+1), flags, 8'h00});
        tag_q.push_back({tg, " R2 R9 flag word"});
    endtask

    // Monitor: every write to the descriptor area must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rx_int)  got_int++;
            if (rx_miss) got_miss++;
            if (mem_req && mem_we && mem_addr < 23'd16) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9 R10 unexpected descriptor write: actual addr=%0h data=%h expected none",
                             mem_addr, mem_wdata);
                end else begin
                    wr_t   e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e.waddr != mem_addr[11:0] || e.data != mem_wdata || mem_be != 2'b11) begin
                        errors++;
                        $display("FAIL %s: actual addr=%0h data=%h be=%b expected addr=%0h data=%h be=11",
                                 t, mem_addr, mem_wdata, mem_be, e.waddr, e.data);
                    end
                end
            end
        end
    end

    task automatic check(bit ok, string tg, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tg, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(int a);
        return a[0] ? mem[a >> 1][15:8] : mem[a >> 1][7:0];
    endfunction

    task automatic push_byte(logic [7:0] d, bit last, bit fr, bit ov, bit cr);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_last = last;
        rx_err_frame = last & fr; rx_err_ovf = last & ov; rx_err_crc = last & cr;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_frame(int n, logic [7:0] seed, bit fr, bit ov, bit cr, string tg);
        int seg_d [8];
        int seg_n [8];
        int seg_o [8];
        int nseg = 0;
        int i = m_idx;
        int i0 = exp_int, m0 = exp_miss;
        if (!m_own[i]) begin
            exp_miss++;
        end else begin
            int  rem = n, stored = 0;
            bit  first = 1'b1, fin = 1'b0;
            while (!fin) begin
                if (rem > cap[i]) begin
                    int nx = (i + 1) & 3;
                    seg_d[nseg] = i; seg_n[nseg] = cap[i]; seg_o[nseg] = stored; nseg++;
                    stored += cap[i];
                    m_own[i] = 1'b0;
                    if (m_own[nx]) begin
                        push_wb(i, first ? 8'h02 : 8'h00, 0, 1'b0, {tg, " R5 chain"});
                        rem -= cap[i];
                        first = 1'b0;
                    end else begin
                        push_wb(i, 8'h45 | (first ? 8'h02 : 8'h00), stored, 1'b1, {tg, " R7 buffer error"});
                        exp_int++;
                        fin = 1'b1;
                    end
                    i = nx;
                end else begin
                    logic [7:0] f;
                    f = 8'h01 | (first ? 8'h02 : 8'h00) | {2'b00, fr, ov, cr, 3'b000};
                    if (fr | ov | cr) f[6] = 1'b1;
                    seg_d[nseg] = i; seg_n[nseg] = rem; seg_o[nseg] = stored; nseg++;
                    stored += rem;
                    push_wb(i, f, stored, 1'b1, {tg, " R4 R6 end"});
                    m_own[i] = 1'b0;
                    exp_int++;
                    i = (i + 1) & 3;
                    fin = 1'b1;
                end
            end
        end
        m_idx = i;
        for (int k = 0; k < n; k++) push_byte(seed + 8'(k), k == n - 1, fr, ov, cr);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, {tg, " R9 all expected writes seen"}, exp_q.size(), 0);
        check(got_int == exp_int, {tg, " R11 rx_int count"}, got_int, exp_int);
        check(got_miss == exp_miss, {tg, " R10 rx_miss count"}, got_miss, exp_miss);
        for (int s = 0; s < nseg; s++) begin
            int bad = 0;
            for (int k = 0; k < seg_n[s]; k++)
                if (rd_byte(buf_base(seg_d[s]) + k) != 8'(seed + 8'(seg_o[s] + k))) bad++;
            check(bad == 0, {tg, " R3 buffer bytes"}, bad, 0);
        end
        if (exp_int == i0 && exp_miss == m0)
            check(1'b0, {tg, " model"}, 0, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        for (int w = 0; w < 4096; w++) mem[w] = 16'h0;
        for (int d = 0; d < 4; d++) set_desc(d, 1'b1);
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!rx_ready && !mem_req && !rx_int && !rx_miss, "R12 outputs in reset",
              {rx_ready, mem_req, rx_int, rx_miss}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!rx_ready && !mem_req, "R12 idle after reset", {rx_ready, mem_req}, 0);

        // R4: single-buffer frame into descriptor 0 (index starts at 0, R12)
        send_frame(20, 8'h10, 1'b0, 1'b0, 1'b0, "R4 single buffer");
        // R5 R6: chained through d1, d2, d3 with a CRC error; index wraps to 0 (R8)
        send_frame(40, 8'h40, 1'b0, 1'b0, 1'b1, "R5 R6 chained");
        // R10: d0 was handed back, so this frame is missed after the wrap (R8)
        send_frame(10, 8'h80, 1'b0, 1'b0, 1'b0, "R10 R8 miss after wrap");
        // R6: framing and overflow errors in one buffer
        set_desc(0, 1'b1);
        send_frame(30, 8'h20, 1'b1, 1'b1, 1'b0, "R6 two errors");
        // R7: d1 owned, d2 host-owned -> buffer error after 16 bytes
        set_desc(1, 1'b1);
        send_frame(25, 8'hA0, 1'b0, 1'b0, 1'b0, "R7 chain to host buffer");
        // R10: next frame starts at host-owned d2
        send_frame(5, 8'hC0, 1'b0, 1'b0, 1'b0, "R10 miss at d2");
        // R3: frame exactly fills a 16-byte buffer, no chain
        set_desc(2, 1'b1);
        set_desc(3, 1'b1);
        send_frame(16, 8'h33, 1'b0, 1'b0, 1'b0, "R3 exact fit");
        // R5 R8: chain across the wrap from d3 into d0
        set_desc(0, 1'b1);
        send_frame(70, 8'h05, 1'b0, 1'b0, 1'b0, "R5 R8 chain across wrap");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule